// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting timer channel driven from a byte-wide register port. A host writes a control byte that picks one of six counting behaviours, the arithmetic (plain binary or four packed decimal digits) and the way the count is transferred (low byte only, high byte only, or low then high). The host then writes the starting count. The channel counts on a single-cycle `cntTick` enable that is synchronous to `clk`. The `gate` input enables counting in some behaviours and triggers it in others. `outLevel` carries the waveform.

A starting count of zero stands for the largest count: 65536 in binary and 10000 in decimal. The counter never stops at zero. The one-shot style behaviours wrap to the all-nines or all-ones value and keep going. The periodic behaviours reload themselves from the stored starting value. The host can read a running count safely by first freezing a snapshot. It can also freeze a status byte that describes the channel's configuration and state.

Top module: `pit_channel`

Command byte (written with `busCtrl` high): if bits [7:6] are 11, the byte is a capture command. In a capture command, bit 5 set freezes the count and bit 4 set freezes the status. Otherwise, if bits [5:4] are 00, the byte is a count-freeze command. Any other byte is a control word, with access in [5:4] (01 low only, 10 high only, 11 low then high), behaviour in [3:1] and decimal select in [0]. The status byte is {outLevel, pending-count flag, access[1:0], behaviour[2:0], decimal}.

## Requirements
- R1: After reset, `outLevel` is low and the status byte reads 0x70 (behaviour 0, binary, low-then-high access, pending count set).
- R2: A control word resets the channel. `outLevel` goes low for behaviour 0 and high for every other behaviour, the pending flag is set, and behaviour codes 6 and 7 act as, and report as, 2 and 3.
- R3: With access 01, a data write sets the low byte and clears the high byte. With access 10, it sets the high byte and clears the low byte. With access 11, two writes give the low byte and then the high byte. Reads of the count follow the same access pattern.
- R4: In behaviour 0, the count loads on the first tick after it is written. Each later tick with gate high decrements it. `outLevel`, which was driven low by the count write, goes high on the tick where the count goes from 1 to 0.
- R5: In behaviour 1, a gate rising edge causes the next tick to load the count and drive `outLevel` low. `outLevel` goes high when the count reaches 0. A new rising edge reloads the count.
- R6: In behaviour 2, `outLevel` is low for one tick in every N ticks. It falls when the count goes from 2 to 1, and the next tick reloads the count.
- R7: In behaviour 3, `outLevel` is high for ceil(N/2) ticks and low for floor(N/2) ticks of every N-tick period. The count decrements by 2.
- R8: In behaviour 4, the count loads on the tick after it is written. `outLevel` drops for exactly one tick when the count reaches 0, and only once per load.
- R9: Behaviour 5 works like behaviour 4, except that a gate rising edge causes the load, and counting ignores the gate level.
- R10: Gate low halts counting in behaviours 0, 2, 3 and 4. In behaviours 2 and 3 it also forces `outLevel` high on the next clock.
- R11: In decimal mode, each digit borrows from 0 to 9. 0x1000 steps to 0x0999, and 0 steps to 0x9999.
- R12: A freeze command captures the count. Later freeze commands are ignored until the snapshot has been fully read, and the reads return the snapshot.
- R13: A frozen status byte is returned by the next read, ahead of any frozen count. Its pending flag clears once the count is loaded.
- R14: In binary mode, a count of 0 steps to 0xFFFF and counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Byte write strobe |
| busRd | input | 1 | Byte read strobe; advances the read sequence |
| busCtrl | input | 1 | High: command byte; low: count data |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Read byte (status, snapshot or live count) |
| cntTick | input | 1 | Counting clock enable, one cycle wide |
| gate | input | 1 | Gate level / trigger input |
| outLevel | output | 1 | Channel waveform output |

## Verification
The hardest case to reach is the odd-count square wave, because the extra high-phase tick only appears at the end of a high half-period. The stimulus loads N=5 and follows the output tick by tick through a full period, then repeats with N=4 for contrast. Trigger-driven reloads need a gate edge to fall between ticks. The stimulus therefore pulses the gate low for one clock with no tick, so that the next tick consumes the captured edge. A repeated freeze command is shown to be ignored by letting the count advance between the two commands and then reading the older value back.

// File: rtl/pit_pkg.sv
package pit_pkg;
  parameter int CNT_W  = 16;
  parameter int BYTE_W = 8;
  localparam int NIB_N = CNT_W / 4;

  typedef enum logic [2:0] {
    M_TCINT    = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } pitMode_t;

  typedef struct packed {
    logic setLow;
    logic setHigh;
    logic zeroLow;
    logic zeroHigh;
    logic loadFull;
    logic loadEven;
    logic decOne;
    logic decTwo;
    logic snap;
  } pitStb_t;

  function automatic pitMode_t decodeMode(input logic [2:0] field);
    pitMode_t m;
    if (field[2:1] == 2'b11) m = pitMode_t'({1'b0, field[1:0]});
    else m = pitMode_t'(field);
    return m;
  endfunction

  function automatic logic [CNT_W-1:0] stepDown(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    if (!bcd) begin
      r = v - CNT_W'(1);
    end else begin
      for (int i = 0; i < NIB_N; i++) begin
        if (borrow) begin
          if (v[i*4 +: 4] == 4'd0) r[i*4 +: 4] = 4'd9;
          else begin
            r[i*4 +: 4] = v[i*4 +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pitStb_t           stb,
  input  logic              bcd,
  input  logic [BYTE_W-1:0] wrByte,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  latchVal,
  output logic              reloadOdd
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [CNT_W-1:0] countQ, reloadQ, latchQ, oneLess, twoLess;

  always_comb begin
    oneLess = stepDown(countQ, bcd);
    twoLess = stepDown(oneLess, bcd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else begin
      if (stb.setLow)   reloadQ[BYTE_W-1:0] <= wrByte;
      if (stb.zeroLow)  reloadQ[BYTE_W-1:0] <= '0;
      if (stb.setHigh)  reloadQ[CNT_W-1:BYTE_W] <= HI_W'(wrByte);
      if (stb.zeroHigh) reloadQ[CNT_W-1:BYTE_W] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (stb.loadFull) begin
      countQ <= reloadQ;
    end else if (stb.loadEven) begin
      countQ <= {reloadQ[CNT_W-1:1], 1'b0};
    end else if (stb.decOne) begin
      countQ <= oneLess;
    end else if (stb.decTwo) begin
      countQ <= twoLess;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) latchQ <= '0;
    else if (stb.snap) latchQ <= countQ;
  end

  assign countVal  = countQ;
  assign latchVal  = latchQ;
  assign reloadOdd = reloadQ[0];
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busCtrl,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              cntTick,
  input  logic              gate,
  input  logic [CNT_W-1:0]  countVal,
  input  logic              reloadOdd,
  output pitStb_t           stb,
  output logic              outLevel,
  output logic              bcdNow,
  output pitMode_t          modeNow,
  output logic              useStatus,
  output logic              useLatch,
  output logic              highByte,
  output logic [BYTE_W-1:0] statusHold
);
  pitMode_t modeQ, nMode, wordMode;
  logic [1:0] accQ, nAcc;
  logic bcdQ, nBcd, outQ, nOut, nullQ, nNull, writtenQ, nWritten;
  logic runQ, nRun, armedQ, nArmed, oddQ, nOdd, trigQ, nTrig, gatePrev;
  logic wrHighQ, nWrHigh, rdHighQ, nRdHigh, latchQ, nLatch, statVQ, nStatV;
  logic [BYTE_W-1:0] statQ, nStat, statusNow;
  logic isCmd, isRb, isLatchCmd, isWord, isData, dataDone, readClear;
  logic tickAct, gateRise, isOne, isTwo, lowFirst, loadReq;

  always_comb begin
    isCmd      = busWr && busCtrl;
    isRb       = isCmd && (busWrData[7:6] == 2'b11);
    isLatchCmd = isCmd && !isRb && (busWrData[5:4] == 2'b00);
    isWord     = isCmd && !isRb && !isLatchCmd;
    isData     = busWr && !busCtrl;
    wordMode   = decodeMode(busWrData[3:1]);
    gateRise   = gate && !gatePrev;
    isOne      = (countVal == CNT_W'(1));
    isTwo      = (countVal == CNT_W'(2));
    lowFirst   = (accQ == 2'b11) && !rdHighQ;
    statusNow  = {outQ, nullQ, accQ, modeQ, bcdQ};
    dataDone   = isData && ((accQ != 2'b11) || wrHighQ);
    readClear  = busRd && !statVQ && !lowFirst;
    tickAct    = cntTick && !isWord;
    loadReq    = writtenQ && ((nullQ && !runQ) || trigQ);
  end

  always_comb begin
    stb = '0;
    nMode = modeQ; nAcc = accQ; nBcd = bcdQ; nOut = outQ; nNull = nullQ;
    nWritten = writtenQ; nRun = runQ; nArmed = armedQ; nOdd = oddQ;
    nTrig = trigQ || gateRise; nWrHigh = wrHighQ; nRdHigh = rdHighQ;
    nLatch = latchQ; nStatV = statVQ; nStat = statQ;

    if (tickAct) begin
      nTrig = gateRise;
      case (modeQ)
        M_TCINT: begin
          if (nullQ) begin
            stb.loadFull = 1'b1; nNull = 1'b0;
          end else if (gate) begin
            stb.decOne = 1'b1;
            if (isOne) nOut = 1'b1;
          end
        end
        M_ONESHOT: begin
          if (trigQ && writtenQ) begin
            stb.loadFull = 1'b1; nNull = 1'b0; nOut = 1'b0;
          end else begin
            stb.decOne = 1'b1;
            if (isOne) nOut = 1'b1;
          end
        end
        M_RATE: begin
          if (loadReq) begin
            stb.loadFull = 1'b1; nNull = 1'b0; nRun = 1'b1; nOut = 1'b1;
          end else if (gate) begin
            if (isOne) begin
              stb.loadFull = 1'b1; nNull = 1'b0; nOut = 1'b1;
            end else begin
              stb.decOne = 1'b1;
              if (isTwo) nOut = 1'b0;
            end
          end
        end
        M_SQUARE: begin
          if (loadReq) begin
            stb.loadEven = 1'b1; nNull = 1'b0; nRun = 1'b1; nOut = 1'b1; nOdd = 1'b0;
          end else if (gate) begin
            if (oddQ) begin
              nOdd = 1'b0; nOut = !outQ; stb.loadEven = 1'b1; nNull = 1'b0;
            end else if (isTwo) begin
              if (outQ && reloadOdd) begin
                stb.decTwo = 1'b1; nOdd = 1'b1;
              end else begin
                nOut = !outQ; stb.loadEven = 1'b1; nNull = 1'b0;
              end
            end else begin
              stb.decTwo = 1'b1;
            end
          end
        end
        M_SWSTROBE, M_HWSTROBE: begin
          if (!outQ) nOut = 1'b1;
          if ((modeQ == M_SWSTROBE) ? nullQ : (trigQ && writtenQ)) begin
            stb.loadFull = 1'b1; nNull = 1'b0; nArmed = 1'b1;
          end else if ((modeQ == M_HWSTROBE) || gate) begin
            stb.decOne = 1'b1;
            if (isOne && armedQ) begin
              nOut = 1'b0; nArmed = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end

    if (((modeQ == M_RATE) || (modeQ == M_SQUARE)) && !gate) nOut = 1'b1;

    if (isData) begin
      stb.setLow   = (accQ == 2'b01) || ((accQ == 2'b11) && !wrHighQ);
      stb.zeroHigh = (accQ == 2'b01);
      stb.setHigh  = (accQ == 2'b10) || ((accQ == 2'b11) && wrHighQ);
      stb.zeroLow  = (accQ == 2'b10);
      if (accQ == 2'b11) nWrHigh = !wrHighQ;
      if (dataDone) begin
        nNull = 1'b1; nWritten = 1'b1;
        if (modeQ == M_TCINT) nOut = 1'b0;
      end
    end

    if (busRd) begin
      if (statVQ) nStatV = 1'b0;
      else if (lowFirst) nRdHigh = 1'b1;
      else begin
        nRdHigh = 1'b0; nLatch = 1'b0;
      end
    end

    if ((isLatchCmd || (isRb && busWrData[5])) && (!latchQ || readClear)) begin
      stb.snap = 1'b1; nLatch = 1'b1; nRdHigh = 1'b0;
    end
    if (isRb && busWrData[4] && !statVQ) begin
      nStatV = 1'b1; nStat = statusNow;
    end

    if (isWord) begin
      nMode = wordMode; nAcc = busWrData[5:4]; nBcd = busWrData[0];
      nOut = (wordMode != M_TCINT); nNull = 1'b1; nWritten = 1'b0;
      nRun = 1'b0; nArmed = 1'b0; nOdd = 1'b0; nTrig = 1'b0;
      nWrHigh = 1'b0; nRdHigh = 1'b0; nLatch = 1'b0; nStatV = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= M_TCINT; accQ <= 2'b11; bcdQ <= 1'b0; outQ <= 1'b0;
      nullQ <= 1'b1; writtenQ <= 1'b0; runQ <= 1'b0; armedQ <= 1'b0;
      oddQ <= 1'b0; trigQ <= 1'b0; gatePrev <= 1'b0; wrHighQ <= 1'b0;
      rdHighQ <= 1'b0; latchQ <= 1'b0; statVQ <= 1'b0; statQ <= '0;
    end else begin
      modeQ <= nMode; accQ <= nAcc; bcdQ <= nBcd; outQ <= nOut;
      nullQ <= nNull; writtenQ <= nWritten; runQ <= nRun; armedQ <= nArmed;
      oddQ <= nOdd; trigQ <= nTrig; gatePrev <= gate; wrHighQ <= nWrHigh;
      rdHighQ <= nRdHigh; latchQ <= nLatch; statVQ <= nStatV; statQ <= nStat;
    end
  end

  assign outLevel   = outQ;
  assign bcdNow     = bcdQ;
  assign modeNow    = modeQ;
  assign useStatus  = statVQ;
  assign useLatch   = latchQ;
  assign highByte   = (accQ == 2'b10) || ((accQ == 2'b11) && rdHighQ);
  assign statusHold = statQ;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busCtrl,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic              cntTick,
  input  logic              gate,
  output logic              outLevel
);
  pitStb_t stb;
  pitMode_t modeNow;
  logic bcdNow, useStatus, useLatch, highByte, reloadOdd;
  logic [CNT_W-1:0] countVal, latchVal, srcWord;
  logic [BYTE_W-1:0] statusHold;

  pit_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busCtrl(busCtrl),
    .busWrData(busWrData), .cntTick(cntTick), .gate(gate), .countVal(countVal),
    .reloadOdd(reloadOdd), .stb(stb), .outLevel(outLevel), .bcdNow(bcdNow),
    .modeNow(modeNow), .useStatus(useStatus), .useLatch(useLatch),
    .highByte(highByte), .statusHold(statusHold)
  );

  pit_datapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .bcd(bcdNow), .wrByte(busWrData),
    .countVal(countVal), .latchVal(latchVal), .reloadOdd(reloadOdd)
  );

  always_comb begin
    srcWord = useLatch ? latchVal : countVal;
    if (useStatus) busRdData = statusHold;
    else if (highByte) busRdData = srcWord[CNT_W-1 -: BYTE_W];
    else busRdData = srcWord[BYTE_W-1:0];
  end
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busCtrl,
  input logic [BYTE_W-1:0] busWrData,
  input logic              cntTick,
  input logic              gate,
  input logic              outLevel,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  latchVal,
  input logic              useLatch,
  input pitMode_t          modeNow
);
  logic ctrlWordIn;
  assign ctrlWordIn = busWr && busCtrl && (busWrData[7:6] != 2'b11) && (busWrData[5:4] != 2'b00);

  assert_gate_low_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((modeNow == M_RATE || modeNow == M_SQUARE) && !gate && !ctrlWordIn) |=> outLevel);

  assert_mode0_word_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWordIn && busWrData[3:1] == 3'd0) |=> !outLevel);

  assert_count_needs_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cntTick |=> $stable(countVal));

  assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == M_SWSTROBE && !outLevel && cntTick && !ctrlWordIn) |=> outLevel);

  assert_hw_strobe_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == M_HWSTROBE && !outLevel && cntTick && !ctrlWordIn) |=> outLevel);

  assert_snapshot_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (useLatch && !(busWr && busCtrl)) |=> (!useLatch || $stable(latchVal)));
endmodule

bind pit_channel pit_channel_chk uChk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busCtrl(busCtrl), .busWrData(busWrData),
  .cntTick(cntTick), .gate(gate), .outLevel(outLevel), .countVal(countVal),
  .latchVal(latchVal), .useLatch(useLatch), .modeNow(modeNow)
);

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;
  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0, busRd = 1'b0, busCtrl = 1'b0;
  logic cntTick = 1'b0, gate = 1'b1, outLevel;
  logic [7:0] busWrData = 8'h00, busRdData;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  pit_channel dut (.clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busCtrl(busCtrl),
    .busWrData(busWrData), .busRdData(busRdData), .cntTick(cntTick), .gate(gate),
    .outLevel(outLevel));

  always #10 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wrCmd(input logic [7:0] b);
    busWr = 1'b1; busCtrl = 1'b1; busWrData = b;
    @(negedge clk); busWr = 1'b0; busCtrl = 1'b0;
  endtask

  task automatic wrData(input logic [7:0] b);
    busWr = 1'b1; busCtrl = 1'b0; busWrData = b;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdByte(output logic [7:0] b);
    busRd = 1'b1; b = busRdData;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      cntTick = 1'b1; @(negedge clk); cntTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic trigger();
    gate = 1'b0; @(negedge clk); gate = 1'b1; @(negedge clk);
  endtask

  task automatic expectSnap(input string req, input int exp);
    logic [7:0] lo, hi;
    wrCmd(8'h00); rdByte(lo); rdByte(hi);
    check(req, {hi, lo}, exp);
  endtask

  task automatic expectStatus(input string req, input int exp);
    logic [7:0] s;
    wrCmd(8'hD0); rdByte(s);
    check(req, s, exp);
  endtask

  task automatic testReset();
    check("R1 out after reset", outLevel, 0);
    expectStatus("R1 status after reset", 8'h70);
  endtask

  task automatic testMode0();
    wrCmd(8'h30); check("R2 mode0 out low", outLevel, 0);
    wrData(8'h05); wrData(8'h00);
    expectStatus("R13 pending before load", 8'h70);
    tick(1); expectStatus("R13 pending cleared", 8'h30);
    tick(4); check("R4 out before terminal", outLevel, 0);
    tick(1); check("R4 out at terminal", outLevel, 1);
    expectSnap("R4 count at zero", 16'h0000);
    tick(1); expectSnap("R14 binary wrap", 16'hFFFF);
    check("R4 out stays high", outLevel, 1);
  endtask

  task automatic testGate0();
    wrCmd(8'h30); wrData(8'h03); wrData(8'h00);
    gate = 1'b0; tick(1); tick(5);
    check("R10 gate low halts out", outLevel, 0);
    expectSnap("R10 gate low halts count", 16'h0003);
    gate = 1'b1; tick(2); check("R10 resume before end", outLevel, 0);
    tick(1); check("R10 resume terminal", outLevel, 1);
  endtask

  task automatic testAccess();
    logic [7:0] b, lo, hi;
    wrCmd(8'h10); wrData(8'h34); tick(1);
    wrCmd(8'h00); rdByte(b); check("R3 low-only read", b, 8'h34);
    wrCmd(8'h20); wrData(8'h12); tick(1);
    wrCmd(8'h00); rdByte(b); check("R3 high-only read", b, 8'h12);
    wrCmd(8'h30); wrCmd(8'h00); rdByte(lo); rdByte(hi);
    check("R3 high-only write clears low", {hi, lo}, 16'h1200);
  endtask

  task automatic testLatch();
    logic [7:0] lo, hi;
    wrCmd(8'h30); wrData(8'h10); wrData(8'h00); tick(1);
    wrCmd(8'h00); tick(3); wrCmd(8'h00);
    rdByte(lo); rdByte(hi); check("R12 second freeze ignored", {hi, lo}, 16'h0010);
    expectSnap("R12 fresh snapshot", 16'h000D);
    wrCmd(8'hF0); rdByte(lo); check("R13 status before count", lo, 8'h30);
    rdByte(lo); rdByte(hi); check("R13 count after status", {hi, lo}, 16'h000D);
  endtask

  task automatic testMode1();
    wrCmd(8'h32); check("R2 mode1 out high", outLevel, 1);
    wrData(8'h03); wrData(8'h00);
    tick(2); check("R5 no trigger no pulse", outLevel, 1);
    trigger(); tick(1); check("R5 trigger drives low", outLevel, 0);
    tick(2); check("R5 still low", outLevel, 0);
    tick(1); check("R5 high at terminal", outLevel, 1);
    trigger(); tick(2); trigger(); tick(1); tick(2);
    check("R5 retrigger extends", outLevel, 0);
    tick(1); check("R5 retrigger terminal", outLevel, 1);
  endtask

  task automatic testMode2();
    wrCmd(8'h3C); expectStatus("R2 code 6 aliases 2", 8'hF4);
    wrData(8'h03); wrData(8'h00);
    tick(1); tick(1); check("R6 high after first step", outLevel, 1);
    tick(1); check("R6 low pulse", outLevel, 0);
    tick(1); check("R6 reload high", outLevel, 1);
    tick(1); check("R6 second period high", outLevel, 1);
    tick(1); check("R6 second period low", outLevel, 0);
  endtask

  task automatic testMode3();
    wrCmd(8'h36); wrData(8'h05); wrData(8'h00); tick(1);
    tick(2); check("R7 odd high phase extra tick", outLevel, 1);
    tick(1); check("R7 odd falls after 3", outLevel, 0);
    tick(1); check("R7 odd low phase", outLevel, 0);
    tick(1); check("R7 odd rises after 2", outLevel, 1);
    wrCmd(8'h36); wrData(8'h04); wrData(8'h00); tick(1);
    tick(1); check("R7 even high", outLevel, 1);
    tick(1); check("R7 even falls after 2", outLevel, 0);
    gate = 1'b0; @(negedge clk);
    check("R10 gate low forces high", outLevel, 1);
    gate = 1'b1; @(negedge clk);
  endtask

  task automatic testMode4();
    wrCmd(8'h38); wrData(8'h03); wrData(8'h00); tick(1);
    tick(2); check("R8 before strobe", outLevel, 1);
    tick(1); check("R8 strobe low", outLevel, 0);
    tick(1); check("R8 strobe one tick", outLevel, 1);
    tick(5); check("R8 strobe only once", outLevel, 1);
  endtask

  task automatic testMode5();
    wrCmd(8'h3A); wrData(8'h02); wrData(8'h00);
    tick(3); check("R9 no strobe without trigger", outLevel, 1);
    trigger(); tick(2); check("R9 before strobe", outLevel, 1);
    tick(1); check("R9 strobe low", outLevel, 0);
    tick(1); check("R9 strobe one tick", outLevel, 1);
  endtask

  task automatic testBcd();
    wrCmd(8'h31); expectStatus("R11 status decimal bit", 8'h71);
    wrData(8'h00); wrData(8'h10); tick(2);
    expectSnap("R11 digit borrow", 16'h0999);
    wrCmd(8'h31); wrData(8'h00); wrData(8'h00); tick(2);
    expectSnap("R11 zero wraps to nines", 16'h9999);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1; @(negedge clk);
    testReset();
    testMode0();
    testGate0();
    testAccess();
    testLatch();
    testMode1();
    testMode2();
    testMode3();
    testMode4();
    testMode5();
    testBcd();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule